// File: doc/BRIEF.md
# Dual-Clock FIFO with Shared Status Flags

This block is a first-in first-out buffer of 2048 words of 9 bits that joins two unrelated clock domains. A producer writes on its own clock with a write enable. A consumer reads on its own clock with a read enable and receives data one read-clock cycle later. Each side keeps a binary pointer, passes it to the other side as Gray code through a two-flop synchroniser, and computes its flags from its own pointer and the synchronised copy of the other pointer.

Status is packed onto three outputs. One active-low output reports "empty or full". A second active-low output reports "almost empty or almost full". A third, active-high output reports half full. Every flag is a register that changes only on an edge of the clock that owns it. A clock edge with its enable low still recomputes that side's flags, so an idle write clock picks up reads that have crossed over since the last edge. A write counts against the capacity as seen from the write side, so a read from the other domain frees space only after it has been synchronised.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words come out in the order they were accepted, and the occupancy never exceeds 2048 words.
- R2: A write enabled while the write side sees 2048 words is ignored. Neither memory nor the count changes.
- R3: A read frees space for the write side only once it has passed the synchroniser. A write on the first write-clock edge after the first read that follows full is still ignored. A later write, once the read is visible, is accepted and fills the FIFO again.
- R4: A write-clock edge with `wr_en` low recomputes the write-side flags. After one read from full with no further writes, `empty_full_n` returns high.
- R5: `empty_full_n` is 0 when the read side sees 0 words or the write side sees 2048 words, and 1 otherwise. All flags are registered outputs.
- R6: A read enabled while the read side sees 0 words is ignored. `rd_data` and the read pointer do not change, and the next word written is the next word read.
- R7: `almost_n` is 0 when the occupancy is 16 words or fewer, or 2032 words or more (thresholds are parameters), and 1 otherwise.
- R8: `half_full` is 1 when the occupancy is greater than 1024 words.
- R9: While both resets are low, the FIFO empties and `empty_full_n`=0, `almost_n`=0, `half_full`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Data to store |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | 9 | Data of the last accepted read |
| empty_full_n | output | 1 | Low when empty (read view) or full (write view) |
| almost_n | output | 1 | Low when near empty or near full |
| half_full | output | 1 | High when more than half the words are in use |

## Verification
The hard case is a write at full that meets a read in the other domain. The read has already freed a slot, but the write side cannot yet see it. The bench fills the FIFO to 2048 words, issues one read, and then drives a write on the very next write-clock edge. That write must be dropped. It then waits with the write enable low, expects `empty_full_n` to rise through idle flag-update edges alone, writes one more word, and drains all 2048 words to prove that the dropped word never entered the memory.

// File: rtl/fifo_pkg.sv
// Package: shared defaults for the dual-clock FIFO.
// Assumes: all FIFO modules take their default widths from here.
package fifo_pkg;
    localparam int unsigned DEF_DATA_W   = 9;
    localparam int unsigned DEF_ADDR_W   = 11;
    localparam int unsigned DEF_AE_LEVEL = 16;
    localparam int unsigned DEF_AF_GAP   = 16;
endpackage

// File: rtl/ptr_gray_sync.sv
// Module: ptr_gray_sync
// Moves a Gray-coded pointer into the destination clock domain through two
// flops, then converts it back to binary for the counting logic there.
// Assumes: the source changes the Gray value by at most one bit per source
// clock edge, so every captured value is either the old or the new pointer.
module ptr_gray_sync #(
    parameter int unsigned W = fifo_pkg::DEF_ADDR_W + 1
) (
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the foreign pointer.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: every bit is the XOR of all Gray bits at or above it.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc        = acc ^ sync_q[i];
            bin_out[i] = acc;
        end
    end
endmodule

// File: rtl/fifo_ram.sv
// Module: fifo_ram
// Storage array with one write port on the write clock and a registered read
// port on the read clock.
// Assumes: the controllers only enable a port for an accepted operation.
module fifo_ram #(
    parameter int unsigned DATA_W = fifo_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W = fifo_pkg::DEF_ADDR_W
) (
    input  logic              wr_clk,
    input  logic              wr_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_re,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one accepted write.
    always_ff @(posedge wr_clk) begin
        if (wr_we) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Register the word of one accepted read; otherwise keep the old data.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_data <= '0;
        end else if (rd_re) begin
            rd_data <= mem[rd_addr];
        end
    end

    // R6
    rd_data_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_re |=> $stable(rd_data));
endmodule

// File: rtl/fifo_wr_side.sv
// Module: fifo_wr_side
// Write pointer, write acceptance and write-domain flags (full, near full,
// half full). Every write-clock edge recomputes the flags from the
// synchronised read pointer, whether or not a write is stored.
// Assumes: rd_bin_s is the read pointer already synchronised to wr_clk.
module fifo_wr_side #(
    parameter int unsigned ADDR_W = fifo_pkg::DEF_ADDR_W,
    parameter int unsigned AF_GAP = fifo_pkg::DEF_AF_GAP
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_bin_s,
    output logic              wr_accept,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              wr_full,
    output logic              wr_afull,
    output logic              wr_half
);
    localparam int unsigned      PTR_W  = ADDR_W + 1;
    localparam logic [PTR_W-1:0] CAP    = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [PTR_W-1:0] HALF   = {2'b01, {(ADDR_W-1){1'b0}}};
    localparam logic [PTR_W-1:0] AF_LVL = CAP - PTR_W'(AF_GAP);

    logic [PTR_W-1:0] wr_bin;
    logic [PTR_W-1:0] cnt_now;
    logic [PTR_W-1:0] bin_nxt;
    logic [PTR_W-1:0] cnt_nxt;

    // Occupancy seen now, acceptance, and the occupancy after this edge.
    always_comb begin
        cnt_now   = wr_bin - rd_bin_s;
        wr_accept = wr_en && (cnt_now != CAP);
        bin_nxt   = wr_bin + {{ADDR_W{1'b0}}, wr_accept};
        cnt_nxt   = bin_nxt - rd_bin_s;
    end

    assign wr_addr = wr_bin[ADDR_W-1:0];

    // Advance the pointer and refresh all write-side flags on every edge.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_bin   <= '0;
            wr_gray  <= '0;
            wr_full  <= 1'b0;
            wr_afull <= 1'b0;
            wr_half  <= 1'b0;
        end else begin
            wr_bin   <= bin_nxt;
            wr_gray  <= bin_nxt ^ (bin_nxt >> 1);
            wr_full  <= (cnt_nxt == CAP);
            wr_afull <= (cnt_nxt >= AF_LVL);
            wr_half  <= (cnt_nxt > HALF);
        end
    end

    // R1
    occupancy_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        cnt_now <= CAP);
    // R2
    full_write_blocked_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && (cnt_now == CAP)) |=> $stable(wr_bin));
    // R1
    wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));
endmodule

// File: rtl/fifo_rd_side.sv
// Module: fifo_rd_side
// Read pointer, read acceptance and read-domain flags (empty, near empty).
// Every read-clock edge recomputes the flags from the synchronised write
// pointer, whether or not a word is read.
// Assumes: wr_bin_s is the write pointer already synchronised to rd_clk.
module fifo_rd_side #(
    parameter int unsigned ADDR_W   = fifo_pkg::DEF_ADDR_W,
    parameter int unsigned AE_LEVEL = fifo_pkg::DEF_AE_LEVEL
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_bin_s,
    output logic              rd_accept,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic              rd_empty,
    output logic              rd_aempty
);
    localparam int unsigned      PTR_W  = ADDR_W + 1;
    localparam logic [PTR_W-1:0] AE_LVL = PTR_W'(AE_LEVEL);

    logic [PTR_W-1:0] rd_bin;
    logic [PTR_W-1:0] cnt_now;
    logic [PTR_W-1:0] bin_nxt;
    logic [PTR_W-1:0] cnt_nxt;

    // Occupancy seen now, acceptance, and the occupancy after this edge.
    always_comb begin
        cnt_now   = wr_bin_s - rd_bin;
        rd_accept = rd_en && (cnt_now != '0);
        bin_nxt   = rd_bin + {{ADDR_W{1'b0}}, rd_accept};
        cnt_nxt   = wr_bin_s - bin_nxt;
    end

    assign rd_addr = rd_bin[ADDR_W-1:0];

    // Advance the pointer and refresh the read-side flags on every edge.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_bin    <= '0;
            rd_gray   <= '0;
            rd_empty  <= 1'b1;
            rd_aempty <= 1'b1;
        end else begin
            rd_bin    <= bin_nxt;
            rd_gray   <= bin_nxt ^ (bin_nxt >> 1);
            rd_empty  <= (cnt_nxt == '0);
            rd_aempty <= (cnt_nxt <= AE_LVL);
        end
    end

    // R6
    empty_read_blocked_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && (cnt_now == '0)) |=> $stable(rd_bin));
    // R1
    rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        1'b1 |=> ($countones(rd_gray ^ $past(rd_gray)) <= 1));
endmodule

// File: rtl/dual_clock_fifo.sv
// Module: dual_clock_fifo (top)
// Dual-clock FIFO with an empty-or-full output, a near-empty-or-near-full
// output (both active low) and an active-high half-full output.
// Assumes: the two resets are asserted together for a few cycles of each
// clock; all outputs are registers or a single gate of registers.
module dual_clock_fifo #(
    parameter int unsigned DATA_W   = fifo_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W   = fifo_pkg::DEF_ADDR_W,
    parameter int unsigned AE_LEVEL = fifo_pkg::DEF_AE_LEVEL,
    parameter int unsigned AF_GAP   = fifo_pkg::DEF_AF_GAP
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_full_n,
    output logic              almost_n,
    output logic              half_full
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic              wr_accept, rd_accept;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PTR_W-1:0]  wr_gray, rd_gray;
    logic [PTR_W-1:0]  wr_bin_s, rd_bin_s;
    logic              wr_full, wr_afull, wr_half;
    logic              rd_empty, rd_aempty;

    fifo_wr_side #(.ADDR_W(ADDR_W), .AF_GAP(AF_GAP)) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .rd_bin_s (rd_bin_s),
        .wr_accept(wr_accept),
        .wr_addr  (wr_addr),
        .wr_gray  (wr_gray),
        .wr_full  (wr_full),
        .wr_afull (wr_afull),
        .wr_half  (wr_half)
    );

    fifo_rd_side #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rd (
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .wr_bin_s (wr_bin_s),
        .rd_accept(rd_accept),
        .rd_addr  (rd_addr),
        .rd_gray  (rd_gray),
        .rd_empty (rd_empty),
        .rd_aempty(rd_aempty)
    );

    ptr_gray_sync #(.W(PTR_W)) u_rd2wr (
        .dst_clk  (wr_clk),
        .dst_rst_n(wr_rst_n),
        .gray_in  (rd_gray),
        .bin_out  (rd_bin_s)
    );

    ptr_gray_sync #(.W(PTR_W)) u_wr2rd (
        .dst_clk  (rd_clk),
        .dst_rst_n(rd_rst_n),
        .gray_in  (wr_gray),
        .bin_out  (wr_bin_s)
    );

    fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk  (wr_clk),
        .wr_we   (wr_accept),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rd_rst_n(rd_rst_n),
        .rd_re   (rd_accept),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Shared flag outputs, each a single gate of registered domain flags.
    assign empty_full_n = !(rd_empty || wr_full);
    assign almost_n     = !(rd_aempty || wr_afull);
    assign half_full    = wr_half;
endmodule

// File: tb/sim_dual_clock_fifo.sv
module sim_dual_clock_fifo;
    localparam int DW   = 9;
    localparam int CAP  = 2048;
    localparam int LOW  = 16;
    localparam int HIGH = CAP - 16;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          empty_full_n, almost_n, half_full;

    int      checks = 0;
    int      errors = 0;
    bit      done = 1'b0;
    logic [DW-1:0] q[$];

    dual_clock_fifo u0 (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty_full_n(empty_full_n), .almost_n(almost_n), .half_full(half_full)
    );

    // 100 MHz on both sides; the read clock lags by 3 ns.
    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    function automatic int exp_ef(input int n);
        return (n == 0 || n == CAP) ? 0 : 1;
    endfunction
    function automatic int exp_al(input int n);
        return (n <= LOW || n >= HIGH) ? 0 : 1;
    endfunction
    function automatic int exp_hf(input int n);
        return (n > CAP / 2) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Let both pointers cross and every flag refresh with enables low.
    task automatic settle();
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        #1;
    endtask

    task automatic flags(input string req, input int n);
        chk({req, " empty_full_n"}, int'(empty_full_n), exp_ef(n));
        chk({req, " almost_n"}, int'(almost_n), exp_al(n));
        chk({req, " half_full"}, int'(half_full), exp_hf(n));
    endtask

    // Back-to-back writes; keep marks whether the model expects them stored.
    task automatic write_n(input int n, input bit keep);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = DW'($urandom);
            @(posedge wr_clk);
            if (keep) q.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // Back-to-back reads, each compared with the model queue.
    task automatic read_n(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] e;
            @(negedge rd_clk);
            rd_en = 1'b1;
            @(posedge rd_clk);
            #1;
            e = q.pop_front();
            chk(req, int'(rd_data), int'(e));
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge wr_clk);
        @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9 empty_full_n", int'(empty_full_n), 0);
        chk("R9 almost_n", int'(almost_n), 0);
        chk("R9 half_full", int'(half_full), 0);
        chk("R9 rd_data", int'(rd_data), 0);

        // R5 one word makes the FIFO neither empty nor full
        write_n(1, 1'b1);
        settle();
        flags("R5 one word", 1);
        read_n(1, "R1 single word");
        settle();
        flags("R5 empty again", 0);

        // R6 read while empty is ignored
        held = rd_data;
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(posedge rd_clk);
        #1;
        rd_en = 1'b0;
        settle();
        chk("R6 rd_data held", int'(rd_data), int'(held));
        write_n(1, 1'b1);
        settle();
        read_n(1, "R6 pointer unmoved");
        settle();

        // R7 and R8 boundaries on the way up
        write_n(16, 1'b1);
        settle();
        chk("R7 at 16", int'(almost_n), 0);
        write_n(1, 1'b1);
        settle();
        chk("R7 at 17", int'(almost_n), 1);
        write_n(CAP / 2 - 17, 1'b1);
        settle();
        chk("R8 at 1024", int'(half_full), 0);
        write_n(1, 1'b1);
        settle();
        chk("R8 at 1025", int'(half_full), 1);
        write_n(HIGH - 1 - q.size(), 1'b1);
        settle();
        chk("R7 at 2031", int'(almost_n), 1);
        write_n(1, 1'b1);
        settle();
        chk("R7 at 2032", int'(almost_n), 0);
        write_n(CAP - q.size(), 1'b1);
        settle();
        flags("R5 full", CAP);

        // R2 writes at full are dropped
        write_n(3, 1'b0);
        settle();
        flags("R2 after blocked writes", CAP);

        // R3 read from full meets a write on the next write edge
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(posedge rd_clk);
        #1;
        rd_en = 1'b0;
        held = q.pop_front();
        chk("R3 first read after full", int'(rd_data), int'(held));
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = DW'($urandom);
        @(posedge wr_clk);
        #1;
        wr_en = 1'b0;
        // R4 idle write edges pull in the read
        settle();
        chk("R4 empty_full_n after idle edges", int'(empty_full_n), 1);
        write_n(1, 1'b1);
        settle();
        chk("R3 refilled", int'(empty_full_n), 0);
        read_n(CAP, "R3 drain order");
        settle();
        flags("R5 drained", 0);

        // R1 random traffic in both domains at once
        fork
            begin
                for (int i = 0; i < 4000; i++) begin
                    bit go;
                    @(negedge wr_clk);
                    go      = (q.size() < CAP - 8) && ($urandom % 100 < 60);
                    wr_en   = go;
                    wr_data = DW'($urandom);
                    @(posedge wr_clk);
                    if (go) q.push_back(wr_data);
                end
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < 4000; i++) begin
                    bit go;
                    logic [DW-1:0] e;
                    @(negedge rd_clk);
                    go    = (q.size() > 8) && ($urandom % 100 < 50);
                    rd_en = go;
                    @(posedge rd_clk);
                    #1;
                    if (go) begin
                        e = q.pop_front();
                        chk("R1 random order", int'(rd_data), int'(e));
                    end
                end
                @(negedge rd_clk);
                rd_en = 1'b0;
            end
        join
        settle();
        flags("R5 after random", q.size());
        read_n(q.size(), "R1 final drain");
        settle();
        flags("R5 final empty", 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule